// File: doc/BRIEF.md
# Presettable Decade Counter with Carry

This block is a single-digit synchronous BCD counter. On each rising clock edge it steps through the codes 0 to 9 and then wraps back to 0. Counting happens only while both count enables are high and no preset is being applied. An active-low load strobe copies a 4-bit preset value into the digit. An active-low reset clears the digit. Reset has the highest priority, load comes next, counting after that, and holding is the default.

A combinational carry output rises while the digit shows nine and the carry-side enable is high. A chain of such counters uses this signal as the next stage's carry-side enable. The count-only enable has no effect on the carry. This lets a stage be paused without breaking the look-ahead chain.

The reset style is chosen at build time. It can clear the digit at once, independent of the clock, or on the next rising edge. Codes 10 to 15 can be preset, and from any of them the counter returns to the decimal loop within two enabled edges.

Top module: `bcd_preset_counter`

## Requirements
- R1: With ASYNC_RESET=1, a low rstN clears count to 0 at once, without waiting for a clock edge. With ASYNC_RESET=0, the clear takes effect on the first rising edge at which rstN is sampled low, and count is unchanged before that edge.
- R2: Reset has priority over load and counting: an edge with rstN low leaves count at 0 whatever loadN, enP and enT are.
- R3: At a rising edge with loadN low and rstN high, count takes the value of presetVal, whatever the enables are (bit 0 least significant, bit 3 most significant). While loadN stays low, count does not advance.
- R4: At a rising edge with rstN, loadN, enP and enT all high and count in 0..8, count becomes count+1.
- R5: At a rising edge with loadN high and either enP or enT low, count keeps its value.
- R6: An enabled edge with count equal to 9 sets count to 0.
- R7: An enabled edge moves the illegal codes as follows: 10→11, 11→6, 12→13, 13→4, 14→15, 15→2. As a result, any code above 9 is back in 0..9 after at most two enabled edges.
- R8: carry is 1 exactly when count equals 9 and enT is 1, with no register stage. It does not depend on enP, and it is 0 whenever enT is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset; asynchronous or synchronous per ASYNC_RESET |
| loadN | input | 1 | Active-low preset strobe |
| presetVal | input | 4 | Value copied in on a load, bit 0 least significant |
| enP | input | 1 | Count enable; does not affect carry |
| enT | input | 1 | Count enable that also gates carry |
| count | output | 4 | Current BCD digit |
| carry | output | 1 | Terminal-count carry for the next stage |

## Verification
An asynchronous build and a synchronous build of the counter are driven with the same stimulus and compared against a behavioural model on every clock. The main sequence presets seven, counts through 8, 9, 0, 1, 2 and 3, and then inhibits. This shows the increment, the wrap and the carry at nine. The counter is then stopped with each enable low in turn, which separates the effect of enP from that of enT on the carry. Each illegal code is then preset and stepped twice, which tells the odd and even recovery paths apart. Finally a reset is dropped between edges while a load is pending, which shows where the two reset styles differ and that reset overrides load.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] TERMINAL = DIGIT_W'(9);

  typedef logic [DIGIT_W-1:0] digit_t;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic clear;      // synchronous clear (used only by the synchronous build)
    logic load;       // take the preset value
    logic advance;    // step to the next code
    logic carryGate;  // enables the terminal-count carry
  } strobe_t;

  // Successor of a code; codes above nine fold back into the decimal loop
  function automatic digit_t nextCode(input digit_t cur);
    digit_t nxt;
    case (cur)
      4'd9:    nxt = 4'd0;
      4'd10:   nxt = 4'd11;
      4'd11:   nxt = 4'd6;
      4'd12:   nxt = 4'd13;
      4'd13:   nxt = 4'd4;
      4'd14:   nxt = 4'd15;
      4'd15:   nxt = 4'd2;
      default: nxt = cur + 4'd1;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
  import dcnt_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic    rstN,
  input  logic    loadN,
  input  logic    enP,
  input  logic    enT,
  output strobe_t strb,
  output logic    arstN
);

  logic countOk;
  assign countOk = enP & enT & loadN;

  generate
    if (ASYNC_RESET) begin : g_async
      // Reset goes straight to the flop's asynchronous clear
      assign arstN      = rstN;
      assign strb.clear = 1'b0;
    end else begin : g_sync
      // Reset becomes an edge-sampled strobe
      assign arstN      = 1'b1;
      assign strb.clear = ~rstN;
    end
  endgenerate

  assign strb.load      = ~loadN;
  assign strb.advance   = countOk;
  assign strb.carryGate = enT;

endmodule

// File: rtl/dcnt_data.sv
module dcnt_data
  import dcnt_pkg::*;
(
  input  logic                clk,
  input  logic                arstN,
  input  strobe_t             strb,
  input  logic [DIGIT_W-1:0]  presetVal,
  output logic [DIGIT_W-1:0]  count,
  output logic                carry
);

  digit_t digitQ;
  digit_t digitD;

  // Priority: clear, then load, then advance, then hold
  always_comb begin
    if (strb.clear)        digitD = '0;
    else if (strb.load)    digitD = presetVal;
    else if (strb.advance) digitD = nextCode(digitQ);
    else                   digitD = digitQ;
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) digitQ <= '0;
    else        digitQ <= digitD;
  end

  assign count = digitQ;
  assign carry = strb.carryGate && (digitQ == TERMINAL);

endmodule

// File: rtl/bcd_preset_counter.sv
module bcd_preset_counter
  import dcnt_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadN,
  input  logic [DIGIT_W-1:0] presetVal,
  input  logic               enP,
  input  logic               enT,
  output logic [DIGIT_W-1:0] count,
  output logic               carry
);

  strobe_t strb;
  logic    arstN;

  dcnt_ctrl #(.ASYNC_RESET(ASYNC_RESET)) u_ctrl (
    .rstN  (rstN),
    .loadN (loadN),
    .enP   (enP),
    .enT   (enT),
    .strb  (strb),
    .arstN (arstN)
  );

  dcnt_data u_data (
    .clk       (clk),
    .arstN     (arstN),
    .strb      (strb),
    .presetVal (presetVal),
    .count     (count),
    .carry     (carry)
  );

endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker
  import dcnt_pkg::*;
#(
  parameter bit ASYNC_RESET = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               loadN,
  input logic [DIGIT_W-1:0] presetVal,
  input logic               enP,
  input logic               enT,
  input logic [DIGIT_W-1:0] count,
  input logic               carry
);

  logic stepOn;
  logic rstSeenLow = 1'b0;
  assign stepOn = enP && enT && loadN;

  // Reset: asynchronous build is already clear at any edge where reset is low;
  // synchronous build is clear one edge after reset was sampled low.
  always_ff @(posedge clk) begin
    rstSeenLow <= ~rstN;
    if (ASYNC_RESET && !rstN)
      assert_reset_clear_R1: assert (count == '0);
    if (!ASYNC_RESET && rstSeenLow)
      assert_reset_clear_R2: assert (count == '0);
  end

  assert_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> count == $past(presetVal));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    stepOn && count < TERMINAL |=> count == $past(count) + 4'd1);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadN && !(enP && enT) |=> $stable(count));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    stepOn && count == TERMINAL |=> count == '0);

  assert_odd_back_R7: assert property (@(posedge clk) disable iff (!rstN)
    stepOn && count > TERMINAL && count[0] |=> count <= TERMINAL);

  assert_even_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    stepOn && count > TERMINAL && !count[0] |=> count == $past(count) + 4'd1);

  assert_carry_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enT |-> !carry);

  assert_carry_nine_R8: assert property (@(posedge clk) disable iff (!rstN)
    carry |-> count == TERMINAL);

endmodule

bind bcd_preset_counter dcnt_checker #(.ASYNC_RESET(ASYNC_RESET)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadN     (loadN),
  .presetVal (presetVal),
  .enP       (enP),
  .enT       (enT),
  .count     (count),
  .carry     (carry)
);

// File: tb/sim_bcd_preset_counter.sv
module sim_bcd_preset_counter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadN = 1'b1;
  logic       enP = 1'b0;
  logic       enT = 1'b0;
  logic [3:0] presetVal = 4'd0;
  logic [3:0] cntA, cntS;
  logic       carA, carS;

  int    total = 0;
  int    bad = 0;
  string phase = "R1";
  bit    cmpOn = 1'b0;
  bit    done = 1'b0;
  int    mA = 0;
  int    mS = 0;

  always #4 clk = ~clk;  // 125 MHz

  bcd_preset_counter #(.ASYNC_RESET(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .loadN(loadN), .presetVal(presetVal),
    .enP(enP), .enT(enT), .count(cntA), .carry(carA));

  bcd_preset_counter #(.ASYNC_RESET(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .loadN(loadN), .presetVal(presetVal),
    .enP(enP), .enT(enT), .count(cntS), .carry(carS));

  // Behavioural model of one edge
  function automatic int modelNext(int c);
    if (!loadN)            return int'(presetVal);
    if (!(enP && enT))     return c;
    if (c < 9)             return c + 1;
    if (c == 9)            return 0;
    if ((c % 2) == 0)      return c + 1;
    return 17 - c;
  endfunction

  always @(posedge clk or negedge rstN)
    if (!rstN) mA = 0; else mA = modelNext(mA);

  always @(posedge clk)
    if (!rstN) mS = 0; else mS = modelNext(mS);

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      check(phase, "async count", int'(cntA), mA);
      check(phase, "sync count", int'(cntS), mS);
      check("R8", "async carry", int'(carA), int'(mA == 9 && enT));
      check("R8", "sync carry", int'(carS), int'(mS == 9 && enT));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    cyc(2);
    cmpOn = 1'b1;
    check("R1", "reset async", int'(cntA), 0);
    check("R1", "reset sync", int'(cntS), 0);

    // Preset seven, count 8 9 0 1 2 3, then inhibit
    rstN = 1'b1; phase = "R3";
    loadN = 1'b0; presetVal = 4'd7; enP = 1'b1; enT = 1'b1;
    cyc(1);
    check("R3", "preset seven", int'(cntA), 7);
    loadN = 1'b1; phase = "R4";
    cyc(1);
    check("R4", "step to 8", int'(cntS), 8);
    cyc(1);
    check("R4", "step to 9", int'(cntA), 9);
    check("R8", "carry at nine", int'(carA), 1);
    phase = "R6";
    cyc(1);
    check("R6", "wrap to 0", int'(cntS), 0);
    cyc(3);
    check("R4", "reach 3", int'(cntA), 3);
    phase = "R5";
    enP = 1'b0;
    cyc(2);
    check("R5", "hold enP low", int'(cntS), 3);
    enP = 1'b1; enT = 1'b0;
    cyc(2);
    check("R5", "hold enT low", int'(cntA), 3);

    // Carry ignores enP, follows enT
    phase = "R8";
    loadN = 1'b0; presetVal = 4'd9; enP = 1'b0; enT = 1'b1;
    cyc(1);
    loadN = 1'b1;
    cyc(2);
    check("R8", "carry with enP low", int'(carS), 1);
    check("R5", "nine held", int'(cntS), 9);
    enT = 1'b0;
    #1;
    check("R8", "carry off with enT low", int'(carA), 0);

    // Load holds counting off while low; bit order
    phase = "R3";
    loadN = 1'b0; presetVal = 4'b0001; enP = 1'b1; enT = 1'b1;
    cyc(2);
    check("R3", "load suppresses count", int'(cntA), 1);
    loadN = 1'b1;
    cyc(1);
    check("R3", "lsb step 1 to 2", int'(cntS), 2);

    // Illegal codes
    phase = "R7";
    for (int v = 10; v <= 15; v++) begin
      loadN = 1'b0; presetVal = 4'(v);
      cyc(1);
      loadN = 1'b1;
      cyc(1);
      check("R7", "first step", int'(cntA), (v % 2 == 0) ? v + 1 : 17 - v);
      cyc(1);
      check("R7", "back in range", int'(cntS <= 4'd9), 1);
    end

    // Reset between edges, with a load pending
    phase = "R3";
    loadN = 1'b0; presetVal = 4'd6;
    cyc(1);
    phase = "R2";
    presetVal = 4'd5;
    rstN = 1'b0;
    #1;
    check("R1", "async clears at once", int'(cntA), 0);
    check("R1", "sync waits for edge", int'(cntS), 6);
    cyc(1);
    check("R2", "reset beats load", int'(cntS), 0);
    rstN = 1'b1; loadN = 1'b1;
    cyc(2);

    cmpOn = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule